// File: doc/BRIEF.md
# Staged Coefficient Commit Engine

This block lets a host change the coefficients of a running signal processor without any audible or visible glitch. The host loads a new memory address and a new data word into one of five staging slots. While it does so, the live memories stay untouched. Once every slot it wants is staged, the host pulses one of two start inputs. One start input selects the parameter memory and the other selects the ramped (target) memory. The engine then copies the staged pairs into the chosen memory through a single write port, one pair per clock.

Only slots whose data register was written since they were last committed take part in a transfer. Each slot keeps a pending flag that is set by a data write and cleared when that slot is copied. The engine walks the slots from lowest to highest index and skips any slot without a pending flag. When the walk ends, the engine raises a one-cycle completion pulse. A start request stays visible on its own output until its completion pulse, and then clears. Requests that arrive while a transfer is running are queued, and the host's staging writes are held off until the running transfer ends.

Top module: `safeload_engine`

## Requirements
- R1: After reset no slot is pending, both request outputs are 0, `stg_wr_ready` is 1, and `ram_we`, `xfer_done` and `xfer_busy` are 0.
- R2: A staging write is taken on a rising clock edge when `stg_wr_en` and `stg_wr_ready` are both 1. If `stg_wr_is_data` is 0, the low address bits of `stg_wr_val` are stored in slot `stg_wr_slot` and the slot is not marked pending. If `stg_wr_is_data` is 1, the whole value is stored as that slot's data and the slot is marked pending. A slot index of 5 or more is ignored.
- R3: A transfer issues exactly one RAM write per pending slot, in ascending slot order, one per clock. Each write carries the slot's staged address unchanged on `ram_addr` (staged address 0 writes memory location 0) and the slot's data on `ram_wdata`.
- R4: `ram_sel` is 0 for writes and completion caused by `start_param`, and 1 for those caused by `start_target`.
- R5: A start pulse sets its request output on the next edge. The request output stays 1 until the cycle in which its transfer asserts `xfer_done`, and it reads 0 from the following cycle on.
- R6: When both requests are outstanding and the engine is idle, the parameter transfer runs first. The target transfer runs after it, starting from the pending state the parameter transfer left behind.
- R7: A start pulse that arrives during a transfer is held and is served after that transfer completes.
- R8: A start sampled on edge E with no slot pending gives `xfer_busy` and `xfer_done` both 1 in the single cycle that follows edge E+1, with no RAM write.
- R9: `stg_wr_ready` is 0 whenever `xfer_busy` is 1. A write held off this way is taken once the transfer ends, and it does not appear in that transfer.
- R10: A committed slot's pending flag is cleared, so a later transfer skips it unless its data register has been written again.
- R11: With N pending slots, the first RAM write appears in the cycle after edge E+1 (where E is the edge that sampled the start). The writes occupy N consecutive cycles, and `xfer_done` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stg_wr_en | input | 1 | Staging write request |
| stg_wr_slot | input | 3 | Staging slot index |
| stg_wr_is_data | input | 1 | 1 = data register, 0 = address register |
| stg_wr_val | input | 32 | Staging write value (address uses low 10 bits) |
| stg_wr_ready | output | 1 | Staging write accepted when high |
| start_param | input | 1 | Start pulse for a parameter memory transfer |
| start_target | input | 1 | Start pulse for a target memory transfer |
| req_param_o | output | 1 | Parameter transfer requested and not yet complete |
| req_target_o | output | 1 | Target transfer requested and not yet complete |
| xfer_busy | output | 1 | Transfer in progress |
| ram_we | output | 1 | Memory write strobe |
| ram_sel | output | 1 | Destination: 0 parameter, 1 target |
| ram_addr | output | 10 | Memory write address |
| ram_wdata | output | 32 | Memory write data |
| xfer_done | output | 1 | One-cycle completion pulse, destination on `ram_sel` |

## Verification
Several faults show up at the ports within the transfer they affect. A pending flag that sticks shows up as a repeated write in the next transfer. A flag that is never set shows up as a missing write. A broken slot order or a wrong address mux shows up as a mismatch in the write stream compared in order. A request latch that loses its value drops a queued transfer, so an expected completion pulse never comes. A wrong arbitration order swaps the destination of the first completion pulse. A stall that leaks lets a late write appear inside the running transfer, and the very next write comparison reports it.

// File: rtl/sl_pkg.sv
package sl_pkg;
  typedef enum logic {
    DEST_PARAM  = 1'b0,
    DEST_TARGET = 1'b1
  } dest_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/sl_stage.sv
module sl_stage #(
  parameter int NSLOT = 5,
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int SW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_fire,
  input  logic [SW-1:0]            wr_slot,
  input  logic                     wr_is_data,
  input  logic [DW-1:0]            wr_val,
  input  logic                     clr_fire,
  input  logic [SW-1:0]            clr_slot,
  output logic [NSLOT-1:0][AW-1:0] slot_addr,
  output logic [NSLOT-1:0][DW-1:0] slot_data,
  output logic [NSLOT-1:0]         pend
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic hit;
    logic clr;
    assign hit = wr_fire && (wr_slot == SW'(g));
    assign clr = clr_fire && (clr_slot == SW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[g] <= '0;
        slot_data[g] <= '0;
        pend[g]      <= 1'b0;
      end else begin
        if (hit && !wr_is_data) slot_addr[g] <= wr_val[AW-1:0];
        if (hit && wr_is_data)  slot_data[g] <= wr_val;
        if (hit && wr_is_data)  pend[g] <= 1'b1;
        else if (clr)           pend[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sl_pick.sv
module sl_pick #(
  parameter int NSLOT = 5,
  parameter int SW    = 3
) (
  input  logic [NSLOT-1:0] pend,
  output logic             any,
  output logic [SW-1:0]    idx
);
  function automatic logic [SW-1:0] lowest_set(input logic [NSLOT-1:0] v);
    logic [SW-1:0] r;
    r = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (v[i]) r = SW'(i);
    end
    return r;
  endfunction

  assign any = |pend;
  assign idx = lowest_set(pend);
endmodule

// File: rtl/sl_ctrl.sv
module sl_ctrl
  import sl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go_param,
  input  logic  go_target,
  input  logic  any_pend,
  output logic  busy,
  output dest_e cur_sel,
  output logic  commit,
  output logic  finish,
  output logic  req_param,
  output logic  req_target
);
  eng_state_e state_q;
  dest_e      sel_q;
  logic       fin_param;
  logic       fin_target;

  assign busy       = (state_q == ST_RUN);
  assign cur_sel    = sel_q;
  assign commit     = busy && any_pend;
  assign finish     = busy && !any_pend;
  assign fin_param  = finish && (sel_q == DEST_PARAM);
  assign fin_target = finish && (sel_q == DEST_TARGET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_param  <= 1'b0;
      req_target <= 1'b0;
    end else begin
      req_param  <= (req_param && !fin_param) || go_param;
      req_target <= (req_target && !fin_target) || go_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= DEST_PARAM;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_param) begin
            state_q <= ST_RUN;
            sel_q   <= DEST_PARAM;
          end else if (req_target) begin
            state_q <= ST_RUN;
            sel_q   <= DEST_TARGET;
          end
        end
        ST_RUN: begin
          if (finish) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/safeload_engine.sv
module safeload_engine
  import sl_pkg::*;
#(
  parameter int NSLOT = 5,
  parameter int AW    = 10,
  parameter int DW    = 32,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stg_wr_en,
  input  logic [SW-1:0] stg_wr_slot,
  input  logic          stg_wr_is_data,
  input  logic [DW-1:0] stg_wr_val,
  output logic          stg_wr_ready,
  input  logic          start_param,
  input  logic          start_target,
  output logic          req_param_o,
  output logic          req_target_o,
  output logic          xfer_busy,
  output logic          ram_we,
  output logic          ram_sel,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          xfer_done
);
  logic [NSLOT-1:0][AW-1:0] slot_addr;
  logic [NSLOT-1:0][DW-1:0] slot_data;
  logic [NSLOT-1:0]         pend;
  logic                     any_pend;
  logic [SW-1:0]            pick_idx;
  logic                     wr_fire;
  logic                     commit;
  logic                     finish;
  logic                     busy;
  dest_e                    cur_sel;

  assign stg_wr_ready = !busy;
  assign wr_fire      = stg_wr_en && stg_wr_ready;

  sl_stage #(.NSLOT(NSLOT), .AW(AW), .DW(DW), .SW(SW)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_slot    (stg_wr_slot),
    .wr_is_data (stg_wr_is_data),
    .wr_val     (stg_wr_val),
    .clr_fire   (commit),
    .clr_slot   (pick_idx),
    .slot_addr  (slot_addr),
    .slot_data  (slot_data),
    .pend       (pend)
  );

  sl_pick #(.NSLOT(NSLOT), .SW(SW)) u_pick (
    .pend (pend),
    .any  (any_pend),
    .idx  (pick_idx)
  );

  sl_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_param   (start_param),
    .go_target  (start_target),
    .any_pend   (any_pend),
    .busy       (busy),
    .cur_sel    (cur_sel),
    .commit     (commit),
    .finish     (finish),
    .req_param  (req_param_o),
    .req_target (req_target_o)
  );

  assign xfer_busy = busy;
  assign ram_we    = commit;
  assign ram_sel   = cur_sel;
  assign ram_addr  = slot_addr[pick_idx];
  assign ram_wdata = slot_data[pick_idx];
  assign xfer_done = finish;
endmodule

// File: rtl/sl_engine_chk.sv
module sl_engine_chk #(
  parameter int NSLOT = 5,
  parameter int SW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_param,
  input logic             busy,
  input logic             ready,
  input logic             we,
  input logic             sel,
  input logic             done,
  input logic             rq_p,
  input logic             rq_t,
  input logic [NSLOT-1:0] pend,
  input logic [SW-1:0]    idx
);
  AST_WE_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && done)); // R3
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    we && $past(we) |-> idx > $past(idx)); // R3
  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> busy); // R9
  AST_STALL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $countones(pend) <= $past($countones(pend))); // R9
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> $countones(pend) == $past($countones(pend)) - 1); // R10
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pend == '0); // R8
  AST_REQ_P_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rq_p && !(done && sel == 1'b0) |=> rq_p); // R5
  AST_REQ_T_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rq_t && !(done && sel == 1'b1) |=> rq_t); // R7
  AST_REQ_P_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done && sel == 1'b0 && !go_param |=> !rq_p); // R5
  AST_PARAM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && $past(rq_p) |-> sel == 1'b0); // R6
  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready); // R9
endmodule

bind safeload_engine sl_engine_chk #(.NSLOT(NSLOT), .SW(SW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .go_param (start_param),
  .busy     (xfer_busy),
  .ready    (stg_wr_ready),
  .we       (ram_we),
  .sel      (ram_sel),
  .done     (xfer_done),
  .rq_p     (req_param_o),
  .rq_t     (req_target_o),
  .pend     (pend),
  .idx      (pick_idx)
);

// File: tb/safeload_engine_tb.sv
module safeload_engine_tb;
  localparam int NSLOT = 5;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int SW    = 3;

  typedef struct {
    bit            is_done;
    bit            sel;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stg_wr_en = 1'b0;
  logic [SW-1:0] stg_wr_slot = '0;
  logic          stg_wr_is_data = 1'b0;
  logic [DW-1:0] stg_wr_val = '0;
  logic          stg_wr_ready;
  logic          start_param = 1'b0;
  logic          start_target = 1'b0;
  logic          req_param_o, req_target_o, xfer_busy;
  logic          ram_we, ram_sel, xfer_done;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  item_t         expq[$];
  logic [AW-1:0] m_addr [NSLOT];
  logic [DW-1:0] m_data [NSLOT];
  bit            m_pend [NSLOT];

  always #5 clk = ~clk;

  safeload_engine #(.NSLOT(NSLOT), .AW(AW), .DW(DW)) u_dut (.*);

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stage_write(input int slot, input bit is_data, input logic [DW-1:0] val);
    stg_wr_en = 1'b1;
    stg_wr_slot = SW'(slot);
    stg_wr_is_data = is_data;
    stg_wr_val = val;
    while (!stg_wr_ready) @(negedge clk);
    @(negedge clk);
    stg_wr_en = 1'b0;
    if (slot < NSLOT) begin
      if (is_data) begin
        m_data[slot] = val;
        m_pend[slot] = 1;
      end else begin
        m_addr[slot] = val[AW-1:0];
      end
    end
  endtask

  task automatic push_xfer(input bit sel);
    item_t it;
    for (int s = 0; s < NSLOT; s++) begin
      if (m_pend[s]) begin
        it.is_done = 0; it.sel = sel; it.addr = m_addr[s]; it.data = m_data[s];
        expq.push_back(it);
        m_pend[s] = 0;
      end
    end
    it.is_done = 1; it.sel = sel; it.addr = '0; it.data = '0;
    expq.push_back(it);
  endtask

  task automatic start_xfer(input bit p, input bit t);
    start_param = p;
    start_target = t;
    @(negedge clk);
    start_param = 1'b0;
    start_target = 1'b0;
    if (p) push_xfer(1'b0);
    if (t) push_xfer(1'b1);
  endtask

  task automatic wait_idle(input bit chk_ready);
    bit seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (xfer_busy && chk_ready && !seen) begin
        check("R9 ready low while busy", stg_wr_ready, 1'b0);
        seen = 1;
      end
      if (!xfer_busy && !req_param_o && !req_target_o) break;
      @(negedge clk);
    end
    check("R3 all expected items seen", expq.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && (ram_we || xfer_done)) begin
      if (expq.size() == 0) begin
        check("R3 unexpected output event", {ram_we, xfer_done}, 2'b00);
      end else begin
        item_t e;
        e = expq.pop_front();
        check("R3 write or done kind", xfer_done, e.is_done);
        check("R4 destination", ram_sel, e.sel);
        if (!e.is_done) begin
          check("R3 address", ram_addr, e.addr);
          check("R3 data", ram_wdata, e.data);
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSLOT; s++) begin m_addr[s] = '0; m_data[s] = '0; m_pend[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", stg_wr_ready, 1'b1);
    check("R1 req_param", req_param_o, 1'b0);
    check("R1 req_target", req_target_o, 1'b0);
    check("R1 busy", xfer_busy, 1'b0);
    check("R1 we/done", {ram_we, xfer_done}, 2'b00);

    // R2 R3: some slots, address-only slot, out-of-range slots
    stage_write(0, 0, 32'h012); stage_write(0, 1, 32'hA0A0_0000);
    stage_write(2, 0, 32'h3FF); stage_write(2, 1, 32'hA0A0_0002);
    stage_write(4, 0, 32'h100); stage_write(4, 1, 32'hA0A0_0004);
    stage_write(1, 0, 32'h055);
    stage_write(5, 1, 32'hDEAD_0005);
    stage_write(7, 1, 32'hDEAD_0007);
    start_xfer(1, 0);
    check("R5 req_param set", req_param_o, 1'b1);
    @(negedge clk);
    check("R11 first write timing", ram_we, 1'b1);
    wait_idle(1);
    check("R5 req_param cleared", req_param_o, 1'b0);

    // R8 R10: nothing pending, exact latency
    start_xfer(0, 1);
    check("R8 not yet busy", xfer_busy, 1'b0);
    @(negedge clk);
    check("R8 busy one cycle", xfer_busy, 1'b1);
    check("R8 done", xfer_done, 1'b1);
    check("R8 no write", ram_we, 1'b0);
    @(negedge clk);
    check("R8 idle after", xfer_busy, 1'b0);
    wait_idle(0);

    // R6: both starts together, address 0 mapping
    stage_write(3, 0, 32'h000); stage_write(3, 1, 32'hB0B0_0003);
    stage_write(1, 1, 32'hB0B0_0001);
    start_xfer(1, 1);
    wait_idle(0);

    // R7: start arrives while busy
    for (int s = 0; s < NSLOT; s++) stage_write(s, 1, 32'hC0C0_0000 + s);
    start_xfer(0, 1);
    @(negedge clk);
    start_param = 1'b1;
    @(negedge clk);
    start_param = 1'b0;
    push_xfer(1'b0);
    check("R7 param request held", req_param_o, 1'b1);
    wait_idle(0);

    // R9: write stalled while busy, then lands after
    stage_write(2, 1, 32'hD0D0_0002);
    stage_write(4, 1, 32'hD0D0_0004);
    start_xfer(1, 0);
    while (!xfer_busy) @(negedge clk);
    check("R9 ready low", stg_wr_ready, 1'b0);
    stage_write(2, 1, 32'hE0E0_0002);
    wait_idle(0);
    start_xfer(0, 1);
    wait_idle(0);

    // R10: no new writes, nothing committed
    start_xfer(1, 0);
    wait_idle(0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule